// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

The unit compares two IEEE-754 operands and reports how they are ordered as a 2-bit condition code. A format input selects single or double precision. It also produces the invalid-operation side effects of an unordered compare: a one-cycle exception request when the invalid trap is enabled, or a sticky accrued-invalid flag when it is not.

A caller presents both operands, the format bit, the trap enable and the current accrued-invalid flag together with a one-cycle start strobe. One clock later the unit raises a done strobe. At the same time it presents the new condition code, the updated accrued-invalid flag and, if needed, the exception request. Code and flag then hold until the next start. Single-precision operands sit in the low 32 bits of each operand bus.

Top module: `fp_cmp_unit`

## Requirements
- R1: If either selected operand is a NaN, the condition code is 3 (unordered). A NaN has an all-ones exponent and a nonzero fraction, and quiet and signalling NaNs are treated alike.
- R2: When operand A is less than operand B, the condition code is 1.
- R3: When operand A is greater than operand B, the condition code is 2.
- R4: Equal operands give condition code 0.
- R5: An unordered result with the trap enable set raises exc_req_o for exactly the done cycle. exc_req_o is never raised otherwise.
- R6: An unordered result with the trap enable clear drives nv_accr_o to 1. In every other case nv_accr_o takes the value of nv_accr_i sampled with the start strobe.
- R7: With dbl_i low, only bits 31:0 of each operand are used: sign at bit 31, 8-bit exponent at 30:23, fraction at 22:0. Bits 63:32 have no effect. With dbl_i high, the full 64 bits are used: sign at 63, 11-bit exponent at 62:52, fraction at 51:0.
- R8: Positive zero and negative zero compare equal (code 0).
- R9: Operands of opposite sign are ordered by sign. For two negative operands the magnitude order is inverted, and infinities take part in the ordering.
- R10: done_o is high in exactly the cycle after each start strobe. fcc_o and nv_accr_o change only in that cycle and hold otherwise.
- R11: While reset is high, and after it, until the first done, fcc_o, nv_accr_o, exc_req_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle compare request |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| nv_trap_en_i | input | 1 | Invalid-operation trap enable |
| nv_accr_i | input | 1 | Current accrued-invalid flag |
| fcc_o | output | 2 | Condition code: 0 eq, 1 lt, 2 gt, 3 unordered |
| nv_accr_o | output | 1 | Updated accrued-invalid flag |
| exc_req_o | output | 1 | Exception request pulse |
| done_o | output | 1 | Result valid strobe |

## Verification
The hardest cases are the ones with special encodings on both sides at once. Examples are two zeros of opposite sign, two negative values that differ only in low fraction bits, a NaN carrying a single fraction bit, and single-precision compares with junk in the upper word. Uniform random data almost never produces these. The stimulus therefore draws each operand from weighted classes (zero, infinity, quiet NaN, signalling NaN, subnormal, normal). It often copies A into B, sometimes flipping the sign or the lowest fraction bit. It also randomises the trap enable, the incoming flag and the gaps between back-to-back starts.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int OPW     = 64;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int MAG_W   = OPW - 1;

  typedef enum logic [1:0] {
    FCC_EQ = 2'd0,
    FCC_LT = 2'd1,
    FCC_GT = 2'd2,
    FCC_UN = 2'd3
  } fcc_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;
endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] raw,
  output opnd_t                 info
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = raw[W-2 -: EXP_W];
  assign frac_f = raw[FRAC_W-1:0];

  always_comb begin
    info       = '0;
    info.sign  = raw[W-1];
    info.mag   = MAG_W'(raw[W-2:0]);
    info.nan   = (&exp_f) && (|frac_f);
    info.zero  = ~|raw[W-2:0];
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  output fcc_e  code
);
  logic mag_lt, mag_eq;

  assign mag_lt = a.mag < b.mag;
  assign mag_eq = a.mag == b.mag;

  always_comb begin
    if (a.nan || b.nan)          code = FCC_UN;
    else if (a.zero && b.zero)   code = FCC_EQ;
    else if (a.sign != b.sign)   code = a.sign ? FCC_LT : FCC_GT;
    else if (mag_eq)             code = FCC_EQ;
    else if (mag_lt ^ a.sign)    code = FCC_LT;
    else                         code = FCC_GT;
  end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fpcmp_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           dbl_i,
  input  logic [OPW-1:0] opa_i,
  input  logic [OPW-1:0] opb_i,
  input  logic           nv_trap_en_i,
  input  logic           nv_accr_i,
  output logic [1:0]     fcc_o,
  output logic           nv_accr_o,
  output logic           exc_req_o,
  output logic           done_o
);
  localparam int SP_W = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W = 1 + DP_EXP + DP_FRAC;

  logic [OPW-1:0] ops [2];
  opnd_t sp_info [2];
  opnd_t dp_info [2];
  opnd_t sel_info [2];
  fcc_e  code;
  logic  unord;

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    fpcmp_unpack #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
      .raw  (ops[i][SP_W-1:0]),
      .info (sp_info[i])
    );
    fpcmp_unpack #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
      .raw  (ops[i][DP_W-1:0]),
      .info (dp_info[i])
    );
    assign sel_info[i] = dbl_i ? dp_info[i] : sp_info[i];
  end

  fpcmp_order u_order (
    .a    (sel_info[0]),
    .b    (sel_info[1]),
    .code (code)
  );

  assign unord = (code == FCC_UN);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcc_o     <= 2'd0;
      nv_accr_o <= 1'b0;
      exc_req_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o    <= start_i;
      exc_req_o <= start_i && unord && nv_trap_en_i;
      if (start_i) begin
        fcc_o     <= code;
        nv_accr_o <= nv_accr_i | (unord & ~nv_trap_en_i);
      end
    end
  end
endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       nv_trap_en_i,
  input logic [1:0] fcc_o,
  input logic       nv_accr_o,
  input logic       exc_req_o,
  input logic       done_o
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o); // R10
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i)); // R10
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(fcc_o) && $stable(nv_accr_o))); // R10
  AST_EXC_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    exc_req_o |-> (done_o && fcc_o == 2'd3)); // R5
  AST_EXC_TRAP_ON: assert property (@(posedge clk) disable iff (rst)
    exc_req_o |-> $past(nv_trap_en_i)); // R5
  AST_UNORD_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (done_o && fcc_o == 2'd3 && $past(nv_trap_en_i)) |-> exc_req_o); // R5
  AST_NV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_o && fcc_o == 2'd3 && !$past(nv_trap_en_i)) |-> nv_accr_o); // R6
endmodule

bind fp_cmp_unit fp_cmp_unit_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .nv_trap_en_i (nv_trap_en_i),
  .fcc_o        (fcc_o),
  .nv_accr_o    (nv_accr_o),
  .exc_req_o    (exc_req_o),
  .done_o       (done_o)
);

// File: tb/tb_fp_cmp_unit.sv
`timescale 1ns/1ps
module tb_fp_cmp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, dbl_i = 1'b0, nv_trap_en_i = 1'b0, nv_accr_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [1:0]  fcc_o;
  logic        nv_accr_o, exc_req_o, done_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_cmp_unit dut (.*);

  // reference state
  int    m_fcc = 0;
  bit    m_nv = 0, m_exc = 0, m_done = 0;
  string m_tag = "R11";

  function automatic bit is_nan(logic [63:0] v, bit dbl);
    if (dbl) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic real to_real(logic [63:0] v, bit dbl);
    real r;
    int  e;
    if (dbl) return $bitstoreal(v);
    e = int'(v[30:23]);
    if (e == 255) r = $bitstoreal(64'h7FF0_0000_0000_0000);
    else if (e == 0) r = real'(v[22:0]) * (2.0 ** (-149));
    else r = (8388608.0 + real'(v[22:0])) * (2.0 ** (e - 150));
    return v[31] ? -r : r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fcc = 0; m_nv = 0; m_exc = 0; m_done = 0; m_tag = "R11";
    end else begin
      m_done = start_i;
      m_exc  = 0;
      if (start_i) begin
        real ra, rb;
        ra = to_real(opa_i, dbl_i);
        rb = to_real(opb_i, dbl_i);
        if (is_nan(opa_i, dbl_i) || is_nan(opb_i, dbl_i)) begin
          m_fcc = 3; m_tag = "R1";
          m_exc = nv_trap_en_i;
          m_nv  = nv_accr_i || !nv_trap_en_i;
        end else begin
          m_nv = nv_accr_i;
          if (ra < rb) begin m_fcc = 1; m_tag = "R2"; end
          else if (ra > rb) begin m_fcc = 2; m_tag = "R3"; end
          else begin m_fcc = 0; m_tag = (ra == 0.0) ? "R8" : "R4"; end
          if (ra < 0.0 && rb < 0.0) m_tag = {m_tag, "/R9"};
        end
        if (!dbl_i) m_tag = {m_tag, "/R7"};
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, int'(fcc_o), m_fcc);
    chk(m_done ? "R6" : "R10/R6 hold", int'(nv_accr_o), int'(m_nv));
    chk("R5", int'(exc_req_o), int'(m_exc));
    chk("R10", int'(done_o), int'(m_done));
  endtask

  function automatic logic [63:0] gen_op(bit dbl);
    logic [63:0] v;
    int cls;
    v = {$urandom, $urandom};
    cls = $urandom_range(0, 9);
    if (dbl) begin
      case (cls)
        0: v[62:0] = '0;
        1: v[62:0] = {11'h7FF, 52'h0};
        2: v[62:51] = 12'hFFF;
        3: begin v[62:51] = 12'hFFE; v[0] = 1'b1; end
        4: v[62:52] = '0;
        default: ;
      endcase
    end else begin
      case (cls)
        0: v[30:0] = '0;
        1: v[30:0] = {8'hFF, 23'h0};
        2: v[30:22] = 9'h1FF;
        3: begin v[30:22] = 9'h1FE; v[0] = 1'b1; end
        4: v[30:23] = '0;
        default: ;
      endcase
    end
    return v;
  endfunction

  initial begin : watchdog
    #1_900_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R11", int'({fcc_o, nv_accr_o, exc_req_o, done_o}), 0);
    rst = 1'b0;
    // directed corners
    begin
      logic [63:0] da [10];
      logic [63:0] db [10];
      bit          dd [10];
      da[0] = 64'h0;                  db[0] = 64'h8000_0000_0000_0000; dd[0] = 1; // R8
      da[1] = 64'hFFFF_FFFF_8000_0000; db[1] = 64'h0;                 dd[1] = 0; // R8 R7
      da[2] = 64'hBFF0_0000_0000_0000; db[2] = 64'hC000_0000_0000_0000; dd[2] = 1; // R9 -1 > -2
      da[3] = 64'h7FF0_0000_0000_0001; db[3] = 64'h0;                 dd[3] = 1; // R1 sNaN
      da[4] = 64'h7F80_0001;          db[4] = 64'h3F80_0000;          dd[4] = 0; // R1
      da[5] = 64'hFF80_0000;          db[5] = 64'h7F80_0000;          dd[5] = 0; // R9 inf
      da[6] = 64'h3FF0_0000_0000_0000; db[6] = 64'h3FF0_0000_0000_0001; dd[6] = 1; // R2
      da[7] = 64'h1234_5678_3F80_0000; db[7] = 64'h3F80_0000;          dd[7] = 0; // R7 R4
      da[8] = 64'h7F80_0000;          db[8] = 64'h7F80_0000;          dd[8] = 0; // R4 inf
      da[9] = 64'h8000_0001;          db[9] = 64'h8000_0002;          dd[9] = 0; // R9 R3
      for (int k = 0; k < 10; k++) begin
        opa_i = da[k]; opb_i = db[k]; dbl_i = dd[k];
        nv_trap_en_i = k[0]; nv_accr_i = k[1];
        start_i = 1'b1;
        @(negedge clk); compare_all();
        start_i = 1'b0;
        @(negedge clk); compare_all();
      end
    end
    for (int n = 0; n < 4000; n++) begin
      dbl_i = $urandom_range(0, 1);
      opa_i = gen_op(dbl_i);
      case ($urandom_range(0, 5))
        0: opb_i = opa_i;
        1: opb_i = opa_i ^ (dbl_i ? 64'h8000_0000_0000_0000 : 64'h8000_0000);
        2: opb_i = opa_i ^ 64'h1;
        default: opb_i = gen_op(dbl_i);
      endcase
      nv_trap_en_i = $urandom_range(0, 1);
      nv_accr_i    = $urandom_range(0, 1);
      start_i      = ($urandom_range(0, 3) != 0);
      @(negedge clk); compare_all();
    end
    start_i = 1'b0;
    repeat (3) begin @(negedge clk); compare_all(); end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule